// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps IEEE 1588 time on its own timestamp clock. The running time has three fields: 48 bits of seconds, 30 bits of nanoseconds and 24 bits of sub-nanosecond fraction, 102 bits in all. On every clock the nanoseconds field grows by a programmable whole-nanosecond step. A separate 24-bit fractional step feeds the fraction field, and each carry out of the fraction adds one more nanosecond. Software picks the two steps so that their sum is one second divided by the clock rate, with the remainder scaled by 2^24. The block has no separate rate-trim register: rate is trimmed only by rewriting the two steps.

Software works through a simple word-wide register port. It can load an absolute time, read a coherent snapshot of the running time, and nudge the time by a signed nanosecond offset without stopping the count. Four pulse inputs mark transmitted and received PTP event frames and transmitted and received peer-delay frames. Each pulse freezes the present seconds and nanoseconds in that channel's capture register, which keeps its value until software collects it.

Register map (word address): 0 seconds [47:32], 1 seconds [31:0], 2 nanoseconds, 3 nanosecond step, 4 fractional step, 5 offset (write only), 6 capture flags. Capture channel k uses addresses 8+4k (nanoseconds word), 9+4k (seconds [31:0]) and 10+4k (seconds [47:32]).

Top module: `ptp_tod_counter`

## Requirements
- R1: On a clock with no load and no offset write, the fraction grows by the fractional step (modulo 2^24) and the nanoseconds grow by the nanosecond step plus the fraction's carry out.
- R2: The nanoseconds field never reaches 1,000,000,000. A sum at or above it has 10^9 taken off and the seconds go up by one; seconds roll over modulo 2^48.
- R3: Writing address 2 loads the time on that clock. The seconds come from the values last written to addresses 0 (bits [15:0]) and 1, the nanoseconds from write data [29:0], and the fraction is set to zero. No step is added on a load clock.
- R4: Writing address 5 applies an offset of write data [29:0] nanoseconds (magnitude below 10^9), subtracted when bit 31 is 1 and added otherwise. A result below zero borrows one second. On that clock no step is added and the fraction is left unchanged.
- R5: A read of address 1 returns the live seconds [31:0] and stores the live nanoseconds and seconds [47:32] into shadow registers. Reads of addresses 2 and 0 return those shadows, which change only on the next read of address 1.
- R6: A pulse on ts_pulse_i[k] while channel k's flag is clear stores the present seconds and nanoseconds in channel k and sets flag bit k of address 6. The channels are ordered: 0 transmit event, 1 receive event, 2 transmit peer-delay, 3 receive peer-delay.
- R7: While a channel's flag is set, further pulses on that channel are ignored and its capture value holds.
- R8: A read of address 8+4k returns the flag in bit 31 and the captured nanoseconds in [29:0], and clears the flag. Addresses 9+4k and 10+4k return captured seconds [31:0] and [47:32].
- R9: After reset the time, the fraction, the shadows and all flags are zero, the nanosecond step (address 3, bits [7:0]) reads 8 and the fractional step (address 4, bits [23:0]) reads 0.
- R10: The steps written to addresses 3 and 4 read back and take effect from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timestamp clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| ts_pulse_i | input | 4 | Frame timestamp pulses, one per capture channel |

## Verification
A wrong step or a lost fraction carry shows up as a nanosecond drift that grows with every clock. The bench runs the counter for a known number of cycles from a loaded time and compares the exact value. A faulty wrap or borrow shows at once as a seconds value off by one, together with a nanoseconds value off by 10^9. The bench places the load or the offset right at the boundary so the first read after it exposes the error. A capture that is not held, or a flag that is not cleared, shows on the next pulse and read pair as a stale or overwritten timestamp.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 30;
  localparam int SUB_W  = 24;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  localparam logic [ADDR_W-1:0] A_SEC_HI = 5'd0;
  localparam logic [ADDR_W-1:0] A_SEC_LO = 5'd1;
  localparam logic [ADDR_W-1:0] A_NSEC   = 5'd2;
  localparam logic [ADDR_W-1:0] A_INC    = 5'd3;
  localparam logic [ADDR_W-1:0] A_SUBINC = 5'd4;
  localparam logic [ADDR_W-1:0] A_ADJ    = 5'd5;
  localparam logic [ADDR_W-1:0] A_CSTAT  = 5'd6;
  localparam int CAP_BASE   = 8;
  localparam int CAP_STRIDE = 4;
endpackage

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  input  logic [NS_W-1:0]  load_ns_i,
  input  logic             adj_i,
  input  logic             adj_neg_i,
  input  logic [NS_W-1:0]  adj_mag_i,
  input  logic [INC_W-1:0] inc_ns_i,
  input  logic [SUB_W-1:0] inc_sub_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam int NSX = NS_W + 2;
  localparam logic [SEC_W-1:0] SEC_ONE = 1;
  localparam logic [NSX-1:0]   NS_WRAP = NSX'(NS_PER_SEC);

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [NS_W-1:0]  ns_q, ns_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [SUB_W:0]   sub_sum;
  logic [NSX-1:0]   ns_sum;

  // priority: load, then offset, then step
  always_comb begin
    sec_d   = sec_q;
    ns_d    = ns_q;
    sub_d   = sub_q;
    sub_sum = {1'b0, sub_q} + {1'b0, inc_sub_i};
    ns_sum  = '0;
    if (load_i) begin
      sec_d = load_sec_i;
      ns_d  = load_ns_i;
      sub_d = '0;
    end else if (adj_i) begin
      if (!adj_neg_i) begin
        ns_sum = NSX'(ns_q) + NSX'(adj_mag_i);
        if (ns_sum >= NS_WRAP) begin
          ns_sum = ns_sum - NS_WRAP;
          sec_d  = sec_q + SEC_ONE;
        end
      end else if (adj_mag_i > ns_q) begin
        ns_sum = NSX'(ns_q) + NS_WRAP - NSX'(adj_mag_i);
        sec_d  = sec_q - SEC_ONE;
      end else begin
        ns_sum = NSX'(ns_q) - NSX'(adj_mag_i);
      end
      ns_d = ns_sum[NS_W-1:0];
    end else begin
      sub_d  = sub_sum[SUB_W-1:0];
      ns_sum = NSX'(ns_q) + NSX'(inc_ns_i) + NSX'(sub_sum[SUB_W]);
      if (ns_sum >= NS_WRAP) begin
        ns_sum = ns_sum - NS_WRAP;
        sec_d  = sec_q + SEC_ONE;
      end
      ns_d = ns_sum[NS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
      sub_q <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
      sub_q <= sub_d;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/ptp_tod_capture.sv
module ptp_tod_capture
  import ptp_tod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             clr_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  output logic             valid_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o
);
  logic             valid_q;
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sec_q   <= '0;
      ns_q    <= '0;
    end else if (pulse_i && !valid_q) begin
      valid_q <= 1'b1;
      sec_q   <= sec_i;
      ns_q    <= ns_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign sec_o   = sec_q;
  assign ns_o    = ns_q;
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int               INC_W      = 8,
  parameter logic [INC_W-1:0] INC_RST    = 8,
  parameter logic [SUB_W-1:0] SUBINC_RST = '0,
  parameter int               N_CAP      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_CAP-1:0]  ts_pulse_i
);
  localparam int SEC_HI_W = SEC_W - 32;

  logic [SEC_W-1:0]    stage_sec;
  logic [INC_W-1:0]    inc_q;
  logic [SUB_W-1:0]    subinc_q;
  logic [NS_W-1:0]     shadow_ns;
  logic [SEC_HI_W-1:0] shadow_sec_hi;
  logic [SEC_W-1:0]    tod_sec;
  logic [NS_W-1:0]     tod_ns;
  logic [SUB_W-1:0]    tod_sub;
  logic                load_we, adj_we, rd_sec;
  logic [N_CAP-1:0]    cap_valid, cap_clr;
  logic [SEC_W-1:0]    cap_sec [N_CAP];
  logic [NS_W-1:0]     cap_ns  [N_CAP];

  assign load_we = reg_we_i && (reg_addr_i == A_NSEC);
  assign adj_we  = reg_we_i && (reg_addr_i == A_ADJ);
  assign rd_sec  = reg_re_i && (reg_addr_i == A_SEC_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_sec     <= '0;
      inc_q         <= INC_RST;
      subinc_q      <= SUBINC_RST;
      shadow_ns     <= '0;
      shadow_sec_hi <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          A_SEC_HI: stage_sec[SEC_W-1:32] <= reg_wdata_i[SEC_HI_W-1:0];
          A_SEC_LO: stage_sec[31:0]       <= reg_wdata_i;
          A_INC:    inc_q                 <= reg_wdata_i[INC_W-1:0];
          A_SUBINC: subinc_q              <= reg_wdata_i[SUB_W-1:0];
          default: ;
        endcase
      end
      if (rd_sec) begin
        shadow_ns     <= tod_ns;
        shadow_sec_hi <= tod_sec[SEC_W-1:32];
      end
    end
  end

  ptp_tod_core #(.INC_W(INC_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_we),
    .load_sec_i (stage_sec),
    .load_ns_i  (reg_wdata_i[NS_W-1:0]),
    .adj_i      (adj_we),
    .adj_neg_i  (reg_wdata_i[DATA_W-1]),
    .adj_mag_i  (reg_wdata_i[NS_W-1:0]),
    .inc_ns_i   (inc_q),
    .inc_sub_i  (subinc_q),
    .sec_o      (tod_sec),
    .ns_o       (tod_ns),
    .sub_o      (tod_sub)
  );

  for (genvar k = 0; k < N_CAP; k++) begin : g_cap
    localparam logic [ADDR_W-1:0] A_NS_K = ADDR_W'(CAP_BASE + CAP_STRIDE * k);
    assign cap_clr[k] = reg_re_i && (reg_addr_i == A_NS_K);
    ptp_tod_capture u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (ts_pulse_i[k]),
      .clr_i   (cap_clr[k]),
      .sec_i   (tod_sec),
      .ns_i    (tod_ns),
      .valid_o (cap_valid[k]),
      .sec_o   (cap_sec[k]),
      .ns_o    (cap_ns[k])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_SEC_HI: reg_rdata_o = DATA_W'(shadow_sec_hi);
      A_SEC_LO: reg_rdata_o = tod_sec[31:0];
      A_NSEC:   reg_rdata_o = DATA_W'(shadow_ns);
      A_INC:    reg_rdata_o = DATA_W'(inc_q);
      A_SUBINC: reg_rdata_o = DATA_W'(subinc_q);
      A_CSTAT:  reg_rdata_o = DATA_W'(cap_valid);
      default: ;
    endcase
    for (int k = 0; k < N_CAP; k++) begin
      if (reg_addr_i == ADDR_W'(CAP_BASE + CAP_STRIDE * k))
        reg_rdata_o = {cap_valid[k], 1'b0, cap_ns[k]};
      if (reg_addr_i == ADDR_W'(CAP_BASE + CAP_STRIDE * k + 1))
        reg_rdata_o = cap_sec[k][31:0];
      if (reg_addr_i == ADDR_W'(CAP_BASE + CAP_STRIDE * k + 2))
        reg_rdata_o = DATA_W'(cap_sec[k][SEC_W-1:32]);
    end
  end
endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker
  import ptp_tod_pkg::*;
#(
  parameter int N_CAP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_we,
  input logic              adj_we,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [SEC_W-1:0]  stage_sec,
  input logic [SEC_W-1:0]  tod_sec,
  input logic [NS_W-1:0]   tod_ns,
  input logic [SUB_W-1:0]  tod_sub,
  input logic [SUB_W-1:0]  subinc_q,
  input logic [N_CAP-1:0]  ts_pulse_i,
  input logic [N_CAP-1:0]  cap_valid,
  input logic [N_CAP-1:0]  cap_clr
);
  localparam logic [SEC_W-1:0] SEC_ONE = 1;

  a_r2_ns_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tod_ns < NS_PER_SEC);

  a_r1_sub_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_we && !adj_we) |=> tod_sub == $past(tod_sub) + $past(subinc_q));

  a_r1_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_we && !adj_we) |=>
      (tod_sec == $past(tod_sec)) || (tod_sec == $past(tod_sec) + SEC_ONE));

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we |=> (tod_ns == $past(reg_wdata_i[NS_W-1:0])) &&
                (tod_sec == $past(stage_sec)) && (tod_sub == '0));

  a_r4_adj_sub_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_we |=> $stable(tod_sub));

  for (genvar k = 0; k < N_CAP; k++) begin : g_chk
    a_r6_cap_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ts_pulse_i[k] && !cap_valid[k]) |=> cap_valid[k]);

    a_r7_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_valid[k] && !cap_clr[k]) |=> cap_valid[k]);

    a_r8_cap_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_valid[k] && cap_clr[k]) |=> !cap_valid[k]);
  end
endmodule

bind ptp_tod_counter ptp_tod_checker #(.N_CAP(N_CAP)) u_chk (.*);

// File: tb/sim_ptp_tod_counter.sv
module sim_ptp_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pulse = '0;
  int          n_chk = 0, n_err = 0;
  logic [31:0] v, w, x;

  always #5 clk = ~clk;

  ptp_tod_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ts_pulse_i(pulse)
  );

  typedef struct packed {
    logic [47:0] s;
    logic [29:0] n;
    logic [7:0]  inc;
    logic [23:0] sub;
    logic [15:0] cyc;
    logic [47:0] es;
    logic [29:0] en;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{48'd5, 30'd100, 8'd0, 24'd0, 16'd10, 48'd5, 30'd100},
    '{48'd0, 30'd0, 8'd8, 24'd0, 16'd20, 48'd0, 30'd160},
    '{48'd7, 30'd1000, 8'd10, 24'h800000, 16'd9, 48'd7, 30'd1094},
    '{48'd1, 30'd999_999_990, 8'd8, 24'd0, 16'd3, 48'd2, 30'd14},
    '{48'h0000_FFFF_FFFF, 30'd999_999_999, 8'd1, 24'd0, 16'd1, 48'h0001_0000_0000, 30'd0},
    '{48'hFFFF_FFFF_FFFF, 30'd999_999_995, 8'd5, 24'd0, 16'd1, 48'd0, 30'd0},
    '{48'h1234_5678_9ABC, 30'd0, 8'd3, 24'hFFFFFF, 16'd4, 48'h1234_5678_9ABC, 30'd15},
    '{48'd42, 30'd123_456_789, 8'd200, 24'd0, 16'd0, 48'd42, 30'd123_456_789}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [47:0] s, input logic [29:0] n);
    wr(5'd0, {16'd0, s[47:32]});
    wr(5'd1, s[31:0]);
    wr(5'd2, {2'b0, n});
  endtask

  task automatic fire(input logic [3:0] m);
    pulse = m;
    @(negedge clk);
    pulse = '0;
  endtask

  // reads seconds low first (snapshot), then shadows
  task automatic snap(output logic [31:0] slo, output logic [31:0] shi, output logic [31:0] ns);
    rd(5'd1, slo);
    rd(5'd0, shi);
    rd(5'd2, ns);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(5'd3, v);  chk("R9 ns step reset", v, 32'd8);
    rd(5'd4, v);  chk("R9 frac step reset", v, 32'd0);
    rd(5'd6, v);  chk("R9 flags reset", v, 32'd0);
    rd(5'd2, v);  chk("R9 ns shadow reset", v, 32'd0);
    rd(5'd0, v);  chk("R9 sec shadow reset", v, 32'd0);
    rd(5'd1, v);  chk("R9 seconds after reset", v, 32'd0);
    rd(5'd8, v);  chk("R9 capture word reset", v, 32'd0);

    // R1 R2 R3 R10 vector walk
    foreach (VECS[i]) begin
      wr(5'd3, {24'd0, VECS[i].inc});
      wr(5'd4, {8'd0, VECS[i].sub});
      rd(5'd3, v); chk("R10 ns step readback", v, {24'd0, VECS[i].inc});
      rd(5'd4, v); chk("R10 frac step readback", v, {8'd0, VECS[i].sub});
      load(VECS[i].s, VECS[i].n);
      idle(int'(VECS[i].cyc));
      snap(v, w, x);
      chk("R1 R2 R3 seconds low", v, VECS[i].es[31:0]);
      chk("R2 R3 seconds high", w, {16'd0, VECS[i].es[47:32]});
      chk("R1 R2 R3 nanoseconds", x, {2'b0, VECS[i].en});
    end

    // R4 offsets with the count frozen
    wr(5'd3, 32'd0);
    wr(5'd4, 32'd0);
    load(48'd10, 30'd500);
    wr(5'd5, 32'd300);
    snap(v, w, x); chk("R4 add ns", x, 32'd800); chk("R4 add sec", v, 32'd10);
    wr(5'd5, 32'h8000_0000 | 32'd600);
    snap(v, w, x); chk("R4 sub ns", x, 32'd200); chk("R4 sub sec", v, 32'd10);
    wr(5'd5, 32'h8000_0000 | 32'd201);
    snap(v, w, x); chk("R4 borrow ns", x, 32'd999_999_999); chk("R4 borrow sec", v, 32'd9);
    wr(5'd5, 32'd1);
    snap(v, w, x); chk("R4 carry ns", x, 32'd0); chk("R4 carry sec", v, 32'd10);
    wr(5'd5, 32'd999_999_999);
    wr(5'd5, 32'd2);
    snap(v, w, x); chk("R4 large add ns", x, 32'd1); chk("R4 large add sec", v, 32'd11);
    load(48'd0, 30'd0);
    wr(5'd5, 32'h8000_0000 | 32'd1);
    snap(v, w, x); chk("R4 borrow from zero ns", x, 32'd999_999_999);
    rd(5'd0, w);   chk("R4 borrow from zero sec hi", w, 32'h0000_FFFF);
    chk("R4 borrow from zero sec lo", v, 32'hFFFF_FFFF);

    // R4 offset clock adds no step
    wr(5'd3, 32'd100);
    load(48'd0, 30'd0);
    wr(5'd5, 32'd5);
    snap(v, w, x); chk("R4 no step on offset clock", x, 32'd5);

    // R4 offset clock leaves fraction alone
    wr(5'd3, 32'd0);
    wr(5'd4, 32'h0080_0000);
    load(48'd0, 30'd0);
    wr(5'd5, 32'd5);
    idle(1);
    snap(v, w, x); chk("R4 fraction unchanged by offset", x, 32'd5);

    // R5 shadow coherence while running
    wr(5'd3, 32'd8);
    wr(5'd4, 32'd0);
    load(48'd3, 30'd0);
    rd(5'd1, v);
    idle(10);
    rd(5'd2, x); chk("R5 ns shadow holds", x, 32'd0);
    rd(5'd0, w); chk("R5 sec shadow holds", w, 32'd0);
    chk("R5 live seconds", v, 32'd3);

    // R6 R7 R8 captures with the count frozen
    wr(5'd3, 32'd0);
    load(48'h0002_0000_0003, 30'd777);
    fire(4'b0010);
    rd(5'd6, v);  chk("R6 flag set ch1", v, 32'h2);
    rd(5'd13, v); chk("R8 ch1 sec low", v, 32'd3);
    rd(5'd14, v); chk("R8 ch1 sec high", v, 32'd2);
    rd(5'd12, v); chk("R6 R8 ch1 ns word", v, 32'h8000_0000 | 32'd777);
    rd(5'd6, v);  chk("R8 flag cleared ch1", v, 32'h0);
    rd(5'd12, v); chk("R8 ch1 ns word after clear", v, 32'd777);

    fire(4'b0001);
    load(48'h0002_0000_0003, 30'd888);
    fire(4'b0001);
    rd(5'd8, v);  chk("R7 ch0 held first time", v, 32'h8000_0000 | 32'd777);
    fire(4'b0001);
    rd(5'd8, v);  chk("R6 ch0 recapture", v, 32'h8000_0000 | 32'd888);

    fire(4'b1100);
    rd(5'd6, v);  chk("R6 flags ch2 ch3", v, 32'hC);
    rd(5'd20, v); chk("R6 ch3 ns word", v, 32'h8000_0000 | 32'd888);
    rd(5'd6, v);  chk("R8 only ch3 cleared", v, 32'h4);
    rd(5'd16, v); chk("R6 ch2 ns word", v, 32'h8000_0000 | 32'd888);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule